// File: doc/BRIEF.md
# ALU Operand Forwarding Path

This block steers the two ALU operands of a five-stage in-order integer pipeline. For each operand it compares the source register number held in the decode/execute register against the destination register of the two younger stages downstream: the execute/memory register and the memory/writeback register. It then emits a 2-bit source select per operand. Each select drives an operand multiplexer. The multiplexer passes either the value latched in decode/execute, the ALU result sitting in execute/memory, or the writeback value (loaded data or an older ALU result).

Alongside the selector and multiplexers sits a register file. Its single write port is fed by the writeback stage and it has two read ports addressed by the decode stage. A read of a register that is being written in the same cycle returns the incoming value, because the write takes effect in the first half of the cycle and the read in the second. Register 0 is hardwired to zero.

Top module: `opnd_fwd_path`

## Requirements
- R1: With no qualifying producer, a select is 00 and the operand equals the value latched in decode/execute; the code 11 is never produced.
- R2: When the execute/memory stage writes (wen high) a non-zero destination equal to the operand's source, the select is 10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback stage writes a non-zero destination equal to the operand's source, the select is 01 and the operand equals the writeback value.
- R4: When both stages qualify for the same source, execute/memory wins (select 10).
- R5: A stage whose write enable is low never forwards, even when its destination matches.
- R6: A destination of register 0 never forwards, even with its write enable high.
- R7: Operand B applies the same rules as operand A to its own source register, independently of operand A.
- R8: A write with a non-zero address is readable from the next cycle on; register 0 always reads zero and writes to it are ignored.
- R9: A read of the register being written in the same cycle returns the value being written.
- R10: Reset clears every register of the register file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| id_rs | input | 5 | Decode-stage read address, port A |
| id_rt | input | 5 | Decode-stage read address, port B |
| rf_rd_a | output | 32 | Register file read data, port A |
| rf_rd_b | output | 32 | Register file read data, port B |
| ex_rs | input | 5 | First source register number in decode/execute |
| ex_rt | input | 5 | Second source register number in decode/execute |
| ex_val_a | input | 32 | First operand value latched in decode/execute |
| ex_val_b | input | 32 | Second operand value latched in decode/execute |
| mem_wen | input | 1 | Execute/memory register-write enable |
| mem_rd | input | 5 | Execute/memory destination register |
| mem_result | input | 32 | ALU result held in execute/memory |
| wb_wen | input | 1 | Memory/writeback register-write enable (also register file write) |
| wb_rd | input | 5 | Memory/writeback destination register |
| wb_value | input | 32 | Memory/writeback value (also register file write data) |
| fwd_sel_a | output | 2 | Source select for operand A (00 pipe, 10 execute/memory, 01 writeback) |
| fwd_sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench builds the block with its default widths: 32-bit data and 5-bit register numbers, which gives a 32-entry register file. Random register numbers are drawn from a narrow window that includes register 0. This makes matches between sources and both destinations frequent, so double matches, zero-destination writes and same-cycle write/read collisions all occur many times. Directed cycles pin down the disabled-write, reset-clearing and read-after-write cases.

// File: rtl/opfw_pkg.sv
package opfw_pkg;
    typedef enum logic [1:0] {
        SEL_PIPE = 2'b00,
        SEL_LATE = 2'b01,
        SEL_NEAR = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/opfw_select.sv
module opfw_select #(
    parameter int AW = 5
) (
    input  logic [AW-1:0]        src,
    input  logic                 near_wen,
    input  logic [AW-1:0]        near_rd,
    input  logic                 late_wen,
    input  logic [AW-1:0]        late_rd,
    output opfw_pkg::opnd_src_e  sel
);
    logic near_hit;
    logic late_hit;

    always_comb begin
        near_hit = near_wen && (near_rd != '0) && (near_rd == src);
        late_hit = late_wen && (late_rd != '0) && (late_rd == src);
        if (near_hit)
            sel = opfw_pkg::SEL_NEAR;
        else if (late_hit)
            sel = opfw_pkg::SEL_LATE;
        else
            sel = opfw_pkg::SEL_PIPE;
    end
endmodule

// File: rtl/opfw_opmux.sv
module opfw_opmux #(
    parameter int DW = 32
) (
    input  opfw_pkg::opnd_src_e sel,
    input  logic [DW-1:0]       pipe_val,
    input  logic [DW-1:0]       near_val,
    input  logic [DW-1:0]       late_val,
    output logic [DW-1:0]       opnd
);
    always_comb begin
        case (sel)
            opfw_pkg::SEL_NEAR: opnd = near_val;
            opfw_pkg::SEL_LATE: opnd = late_val;
            default:            opnd = pipe_val;
        endcase
    end
endmodule

// File: rtl/opfw_regfile.sv
module opfw_regfile #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           wa,
    input  logic [DW-1:0]           wd,
    input  logic [NRD-1:0][AW-1:0]  ra,
    output logic [NRD-1:0][DW-1:0]  rd
);
    localparam int NREG = 1 << AW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t st_d;
    rf_state_t st_q;
    logic      wr_live;

    assign wr_live = we && (wa != '0);

    always_comb begin
        st_d = st_q;
        if (wr_live)
            st_d.regs[wa] = wd;
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        always_comb begin
            if (wr_live && (ra[p] == wa))
                rd[p] = wd;
            else
                rd[p] = st_q.regs[ra[p]];
        end
    end

    // R8: a live write is stored in the addressed entry
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> (st_q.regs[$past(wa)] == $past(wd)));

    // R8: entry zero stays zero
    p_zero_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[0] == '0);
endmodule

// File: rtl/opnd_fwd_path.sv
module opnd_fwd_path #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    output logic [DW-1:0] rf_rd_a,
    output logic [DW-1:0] rf_rd_b,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic [DW-1:0] ex_val_a,
    input  logic [DW-1:0] ex_val_b,
    input  logic          mem_wen,
    input  logic [AW-1:0] mem_rd,
    input  logic [DW-1:0] mem_result,
    input  logic          wb_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic [DW-1:0] wb_value,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    localparam int NOP = 2;

    logic [NOP-1:0][AW-1:0]   src_num;
    logic [NOP-1:0][DW-1:0]   pipe_val;
    logic [NOP-1:0][DW-1:0]   opnd_v;
    opfw_pkg::opnd_src_e      sel_v [NOP];
    logic [NOP-1:0][AW-1:0]   rf_ra;
    logic [NOP-1:0][DW-1:0]   rf_rd;

    assign src_num  = {ex_rt, ex_rs};
    assign pipe_val = {ex_val_b, ex_val_a};
    assign rf_ra    = {id_rt, id_rs};

    for (genvar k = 0; k < NOP; k++) begin : g_opnd
        opfw_select #(.AW(AW)) u_sel (
            .src      (src_num[k]),
            .near_wen (mem_wen),
            .near_rd  (mem_rd),
            .late_wen (wb_wen),
            .late_rd  (wb_rd),
            .sel      (sel_v[k])
        );
        opfw_opmux #(.DW(DW)) u_mux (
            .sel      (sel_v[k]),
            .pipe_val (pipe_val[k]),
            .near_val (mem_result),
            .late_val (wb_value),
            .opnd     (opnd_v[k])
        );
    end

    opfw_regfile #(.DW(DW), .AW(AW), .NRD(NOP)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_wen),
        .wa    (wb_rd),
        .wd    (wb_value),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    assign fwd_sel_a = sel_v[0];
    assign fwd_sel_b = sel_v[1];
    assign opnd_a    = opnd_v[0];
    assign opnd_b    = opnd_v[1];
    assign rf_rd_a   = rf_rd[0];
    assign rf_rd_b   = rf_rd[1];

    // R1: the reserved code never leaves the selectors
    p_no_code11_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    // R4: the nearer stage takes operand A when it qualifies
    p_near_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && (mem_rd != '0) && (mem_rd == ex_rs))
        |-> ((fwd_sel_a == 2'b10) && (opnd_a == mem_result)));

    // R5: nothing is forwarded while both producers are idle
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wen && !wb_wen)
        |-> ((fwd_sel_a == 2'b00) && (fwd_sel_b == 2'b00) && (opnd_b == ex_val_b)));

    // R6: source register 0 is never forwarded
    p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rt == '0) |-> ((fwd_sel_b == 2'b00) && (opnd_b == ex_val_b)));

    // R9: same-cycle write is visible on the read port
    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && (wb_rd != '0) && (id_rs == wb_rd)) |-> (rf_rd_a == wb_value));
endmodule

// File: tb/opnd_fwd_path_test.sv
`timescale 1ns/1ps
module opnd_fwd_path_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  id_rs, id_rt, ex_rs, ex_rt, mem_rd, wb_rd;
    logic [31:0] ex_val_a, ex_val_b, mem_result, wb_value;
    logic        mem_wen, wb_wen;
    logic [31:0] rf_rd_a, rf_rd_b, opnd_a, opnd_b;
    logic [1:0]  fwd_sel_a, fwd_sel_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] model_rf [32];

    always #5 clk = ~clk;

    opnd_fwd_path uut (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
        .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_val_a(ex_val_a), .ex_val_b(ex_val_b), .mem_wen(mem_wen),
        .mem_rd(mem_rd), .mem_result(mem_result), .wb_wen(wb_wen),
        .wb_rd(wb_rd), .wb_value(wb_value), .fwd_sel_a(fwd_sel_a),
        .fwd_sel_b(fwd_sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    always @(posedge clk) begin
        if (!rst_n)
            for (int i = 0; i < 32; i++) model_rf[i] <= '0;
        else if (wb_wen && wb_rd != 0)
            model_rf[wb_rd] <= wb_value;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected select: 2 = execute/memory, 1 = writeback, 0 = pipe value
    function automatic int pick(logic [4:0] src);
        if (mem_wen && mem_rd != 0 && mem_rd == src) return 2;
        if (wb_wen && wb_rd != 0 && wb_rd == src) return 1;
        return 0;
    endfunction

    function automatic string tag_a();
        bit n = mem_wen && mem_rd != 0 && mem_rd == ex_rs;
        bit l = wb_wen && wb_rd != 0 && wb_rd == ex_rs;
        if (n && l) return "R4";
        if (n) return "R2";
        if (l) return "R3";
        if (ex_rs == 0 && ((mem_wen && mem_rd == 0) || (wb_wen && wb_rd == 0))) return "R6";
        if ((!mem_wen && mem_rd == ex_rs) || (!wb_wen && wb_rd == ex_rs)) return "R5";
        return "R1";
    endfunction

    function automatic logic [31:0] rf_expect(logic [4:0] a);
        if (a == 0) return '0;
        if (wb_wen && wb_rd == a) return wb_value;
        return model_rf[a];
    endfunction

    task automatic compare();
        int pa = pick(ex_rs);
        int pb = pick(ex_rt);
        logic [31:0] ea = (pa == 2) ? mem_result : (pa == 1) ? wb_value : ex_val_a;
        logic [31:0] eb = (pb == 2) ? mem_result : (pb == 1) ? wb_value : ex_val_b;
        string ta = tag_a();
        check(ta, "fwd_sel_a", {30'd0, fwd_sel_a}, (pa == 2) ? 32'd2 : (pa == 1) ? 32'd1 : 32'd0);
        check(ta, "opnd_a", opnd_a, ea);
        check("R7", "fwd_sel_b", {30'd0, fwd_sel_b}, (pb == 2) ? 32'd2 : (pb == 1) ? 32'd1 : 32'd0);
        check("R7", "opnd_b", opnd_b, eb);
        if (rst_n) begin
            check((wb_wen && wb_rd != 0 && wb_rd == id_rs) ? "R9" : "R8", "rf_rd_a", rf_rd_a, rf_expect(id_rs));
            check((wb_wen && wb_rd != 0 && wb_rd == id_rt) ? "R9" : "R8", "rf_rd_b", rf_rd_b, rf_expect(id_rt));
        end
    endtask

    task automatic quiet();
        id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; mem_rd = 0; wb_rd = 0;
        ex_val_a = 32'hA0A0_0001; ex_val_b = 32'hB0B0_0002;
        mem_result = 32'hCC00_0003; wb_value = 32'hDD00_0004;
        mem_wen = 0; wb_wen = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        quiet();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R10: after reset every entry reads zero
        @(negedge clk); id_rs = 5'd9; id_rt = 5'd31; #1;
        check("R10", "rf_rd_a after reset", rf_rd_a, 32'd0);
        check("R10", "rf_rd_b after reset", rf_rd_b, 32'd0);

        // R9 and R8: write reg 5, same-cycle bypass then stored value
        @(negedge clk); wb_wen = 1; wb_rd = 5; wb_value = 32'h1234_5678; id_rs = 5; #1; compare();
        @(negedge clk); wb_wen = 0; wb_value = 32'h0; #1; compare();
        check("R8", "stored reg5", rf_rd_a, 32'h1234_5678);

        // R8: writing register 0 is ignored
        @(negedge clk); wb_wen = 1; wb_rd = 0; wb_value = 32'hFFFF_FFFF; id_rt = 0; #1; compare();
        @(negedge clk); wb_wen = 0; #1;
        check("R8", "reg0 reads zero", rf_rd_b, 32'd0);

        // R2, R3, R4, R7 directed
        @(negedge clk); quiet(); mem_wen = 1; mem_rd = 3; ex_rs = 3; ex_rt = 4; #1; compare();
        check("R2", "near select", {30'd0, fwd_sel_a}, 32'd2);
        @(negedge clk); quiet(); wb_wen = 1; wb_rd = 4; ex_rt = 4; ex_rs = 7; #1; compare();
        check("R3", "late select on B R7", {30'd0, fwd_sel_b}, 32'd1);
        @(negedge clk); quiet(); mem_wen = 1; wb_wen = 1; mem_rd = 6; wb_rd = 6; ex_rs = 6; #1; compare();
        check("R4", "near wins", opnd_a, mem_result);

        // R5: disabled writers with matching destinations
        @(negedge clk); quiet(); mem_rd = 2; wb_rd = 2; ex_rs = 2; ex_rt = 2; #1; compare();
        check("R5", "no forward when wen low", opnd_a, ex_val_a);

        // R6: enabled writers to register 0
        @(negedge clk); quiet(); mem_wen = 1; wb_wen = 1; #1; compare();
        check("R6", "zero dest not forwarded", {30'd0, fwd_sel_a}, 32'd0);

        // Random cycles over a narrow register window
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
            ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
            mem_rd = 5'($urandom_range(0, 3)); wb_rd = 5'($urandom_range(0, 3));
            mem_wen = 1'($urandom); wb_wen = 1'($urandom);
            ex_val_a = $urandom; ex_val_b = $urandom;
            mem_result = $urandom; wb_value = $urandom;
            #1; compare();
        end

        // R10: reset after writes clears the entries
        @(negedge clk); quiet(); wb_wen = 1; wb_rd = 12; wb_value = 32'h5A5A_5A5A;
        @(negedge clk); quiet(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; id_rs = 12; #1;
        check("R10", "reg12 cleared", rf_rd_a, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule